// File: doc/BRIEF.md
# Per-Flow Round-Robin Deflection Queue Manager

This block holds the cell queues of one port in a folded, load-balanced packet switch with N ports. Fixed-size cells arrive from the local line side, each tagged with the output port it is heading for. The block spreads each destination's traffic evenly over every port of the switch. It keeps one round-robin pointer per destination, and that pointer picks which balancing queue, and so which intermediate port, the cell will be deflected through. Cells that other ports have deflected here arrive from the fabric. They are sorted into forwarding queues by the final destination that every cell carries.

Both queue banks (N balancing, N forwarding) are held as linked lists in one shared cell memory of DEPTH slots. A bitmap allocator tracks the free slots. In each time slot the fabric presents the peer port it currently connects. The block then shows the head cell of the balancing queue and of the forwarding queue for that peer, and pops either one on request. Up to two arrivals and two departures may happen in the same cycle. An arrival that finds no free slot is dropped and counted.

Top module: `defl_queue_mgr`

## Requirements
- R1: After reset every queue is empty, all round-robin pointers are 0, all DEPTH slots are free and the drop counter reads 0.
- R2: An accepted local cell with destination j is written to the balancing queue named by pointer j. Pointer j then advances by one, modulo N. Pointers of other destinations are unchanged.
- R3: An accepted fabric cell is written to the forwarding queue whose index equals its carried destination. No round-robin pointer moves.
- R4: Every queue is first-in first-out, and a cell keeps the data and destination it arrived with.
- R5: `bal_valid`/`bal_data`/`bal_dest` show the head of balancing queue `peer`, and `fwd_*` show the head of forwarding queue `peer`. A cell accepted in cycle t is visible from cycle t+1.
- R6: `bal_rd` (`fwd_rd`) removes the shown head when that queue is non-empty. A read of an empty queue has no effect.
- R7: An arrival and a read on the same queue in the same cycle both take effect. On an empty queue the read is ignored, and on a one-cell queue the new cell becomes the only cell.
- R8: `bal_level` and `fwd_level` give the number of cells in the two queues selected by `peer`.
- R9: All 2N queues together hold at most DEPTH cells. A cell arriving with no free slot is discarded, the drop counter rises by one for each discarded cell, and a discarded local cell leaves its pointer unmoved.
- R10: When both a local and a fabric cell arrive and exactly one slot is free, the fabric cell is stored and the local cell is dropped.
- R11: A slot released by a read in cycle t can be allocated from cycle t+1 onward, not in cycle t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local cell arrives this cycle |
| loc_dest | input | log2(N) | Final output port of the local cell |
| loc_data | input | DW | Local cell payload |
| dfl_valid | input | 1 | Deflected cell arrives from the fabric |
| dfl_dest | input | log2(N) | Final output port carried by the deflected cell |
| dfl_data | input | DW | Deflected cell payload |
| peer | input | log2(N) | Port currently connected by the fabric |
| bal_rd | input | 1 | Pop head of balancing queue `peer` |
| fwd_rd | input | 1 | Pop head of forwarding queue `peer` |
| bal_valid | output | 1 | Balancing queue `peer` is non-empty |
| bal_data | output | DW | Head payload of balancing queue `peer` |
| bal_dest | output | log2(N) | Head final destination of balancing queue `peer` |
| bal_level | output | log2(DEPTH+1) | Occupancy of balancing queue `peer` |
| fwd_valid | output | 1 | Forwarding queue `peer` is non-empty |
| fwd_data | output | DW | Head payload of forwarding queue `peer` |
| fwd_dest | output | log2(N) | Head final destination of forwarding queue `peer` |
| fwd_level | output | log2(DEPTH+1) | Occupancy of forwarding queue `peer` |
| drop_count | output | DROP_W | Number of discarded cells, wrapping |

## Verification
The bench sends runs of local cells to one destination and interleaves destinations. A design that shared one pointer between destinations, or moved the pointer on a dropped cell, would put cells into the wrong balancing queue. It reads and writes a queue in the same cycle while that queue holds zero, one and several cells. Getting the linked-list update wrong there loses or duplicates cells, or breaks FIFO order. It fills the shared memory to check the overflow path. A fabric cell and a local cell then compete for the last slot, and a slot is released in the same cycle as an arrival. Wrong priority, or reuse of the slot just released, shows up as a stored cell that should have been dropped, a wrong drop count, or corrupted heads.

// File: rtl/dqm_pkg.sv
package dqm_pkg;

    // Which bank a queue index belongs to
    typedef enum logic {
        BANK_BAL = 1'b0,
        BANK_FWD = 1'b1
    } bank_e;

    // Advance a pointer by one with wrap at n
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/dqm_rr_spreader.sv
module dqm_rr_spreader #(
    parameter int unsigned N = 4,
    localparam int unsigned PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] dest_i,
    input  logic          acc_i,
    output logic [PW-1:0] sel_o
);

    typedef struct packed {
        logic [N-1:0][PW-1:0] ptr;
    } rr_st_t;

    rr_st_t s_d, s_q;

    assign sel_o = s_q.ptr[dest_i];

    always_comb begin
        s_d = s_q;
        if (acc_i) begin
            s_d.ptr[dest_i] = PW'(dqm_pkg::wrap_inc(32'(s_q.ptr[dest_i]), N));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_RR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |=> s_q.ptr[$past(dest_i)] != $past(sel_o)); // R2

endmodule

// File: rtl/dqm_slot_pool.sv
module dqm_slot_pool #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned SW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_dfl_i,
    input  logic          req_loc_i,
    input  logic          rel_a_v_i,
    input  logic [SW-1:0] rel_a_slot_i,
    input  logic          rel_b_v_i,
    input  logic [SW-1:0] rel_b_slot_i,
    output logic          gnt_dfl_o,
    output logic [SW-1:0] slot_dfl_o,
    output logic          gnt_loc_o,
    output logic [SW-1:0] slot_loc_o
);

    typedef struct packed {
        logic [DEPTH-1:0] free;
    } pool_st_t;

    pool_st_t s_d, s_q;

    logic [SW-1:0] lo_idx, hi_idx;
    logic          have_one, have_two;

    // Lowest and highest free slot
    always_comb begin
        lo_idx = '0;
        hi_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (s_q.free[i]) lo_idx = SW'(i);
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (s_q.free[i]) hi_idx = SW'(i);
        end
    end

    assign have_one   = |s_q.free;
    assign have_two   = have_one && (lo_idx != hi_idx);
    assign gnt_dfl_o  = req_dfl_i && have_one;
    assign slot_dfl_o = lo_idx;
    assign gnt_loc_o  = req_loc_i && (req_dfl_i ? have_two : have_one);
    assign slot_loc_o = req_dfl_i ? hi_idx : lo_idx;

    always_comb begin
        s_d = s_q;
        if (gnt_dfl_o) s_d.free[slot_dfl_o]   = 1'b0;
        if (gnt_loc_o) s_d.free[slot_loc_o]   = 1'b0;
        if (rel_a_v_i) s_d.free[rel_a_slot_i] = 1'b1;
        if (rel_b_v_i) s_d.free[rel_b_slot_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.free <= '1;
        else        s_q      <= s_d;
    end

    AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_loc_o |-> s_q.free[slot_loc_o]); // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.free == '0) |-> (!gnt_dfl_o && !gnt_loc_o)); // R9
    AST_DFL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_dfl_i && req_loc_i && $countones(s_q.free) == 1) |-> (gnt_dfl_o && !gnt_loc_o)); // R10
    AST_REL_IN_USE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_a_v_i |-> !s_q.free[rel_a_slot_i]); // R11

endmodule

// File: rtl/dqm_queue_ctrl.sv
module dqm_queue_ctrl #(
    parameter int unsigned N     = 4,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW = $clog2(N),
    localparam int unsigned SW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned Q  = 2 * N,
    localparam int unsigned QW = $clog2(Q)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_bal_v_i,
    input  logic [PW-1:0] enq_bal_q_i,
    input  logic [SW-1:0] enq_bal_slot_i,
    input  logic          enq_fwd_v_i,
    input  logic [PW-1:0] enq_fwd_q_i,
    input  logic [SW-1:0] enq_fwd_slot_i,
    input  logic [PW-1:0] peer_i,
    input  logic          bal_rd_i,
    input  logic          fwd_rd_i,
    output logic [SW-1:0] bal_head_o,
    output logic [SW-1:0] fwd_head_o,
    output logic [CW-1:0] bal_cnt_o,
    output logic [CW-1:0] fwd_cnt_o,
    output logic          rel_bal_v_o,
    output logic [SW-1:0] rel_bal_slot_o,
    output logic          rel_fwd_v_o,
    output logic [SW-1:0] rel_fwd_slot_o
);

    typedef struct packed {
        logic [Q-1:0][SW-1:0]     head;
        logic [Q-1:0][SW-1:0]     tail;
        logic [Q-1:0][CW-1:0]     cnt;
        logic [DEPTH-1:0][SW-1:0] link;
    } qc_st_t;

    qc_st_t s_d, s_q;

    logic [Q-1:0]         enq_v;
    logic [Q-1:0]         deq_v;
    logic [Q-1:0][SW-1:0] enq_slot;
    logic [QW-1:0]        bal_idx, fwd_idx;
    int unsigned          occ_sum;

    // Per-queue request decode; the bank is picked by queue index
    for (genvar q = 0; q < Q; q++) begin : g_dec
        localparam dqm_pkg::bank_e BK = (q < N) ? dqm_pkg::BANK_BAL : dqm_pkg::BANK_FWD;
        localparam int unsigned IDX = (q < N) ? q : q - N;
        if (BK == dqm_pkg::BANK_BAL) begin : g_bal
            assign enq_v[q]    = enq_bal_v_i && (enq_bal_q_i == PW'(IDX));
            assign enq_slot[q] = enq_bal_slot_i;
            assign deq_v[q]    = bal_rd_i && (peer_i == PW'(IDX));
        end else begin : g_fwd
            assign enq_v[q]    = enq_fwd_v_i && (enq_fwd_q_i == PW'(IDX));
            assign enq_slot[q] = enq_fwd_slot_i;
            assign deq_v[q]    = fwd_rd_i && (peer_i == PW'(IDX));
        end
    end

    assign bal_idx = QW'(peer_i);
    assign fwd_idx = QW'(N) + QW'(peer_i);

    always_comb begin
        s_d = s_q;
        for (int q = 0; q < Q; q++) begin
            if (enq_v[q] && deq_v[q] && s_q.cnt[q] != '0) begin
                if (s_q.cnt[q] == CW'(1)) begin
                    s_d.head[q] = enq_slot[q];
                end else begin
                    s_d.link[s_q.tail[q]] = enq_slot[q];
                    s_d.head[q]           = s_q.link[s_q.head[q]];
                end
                s_d.tail[q] = enq_slot[q];
            end else if (enq_v[q]) begin
                if (s_q.cnt[q] == '0) s_d.head[q] = enq_slot[q];
                else                  s_d.link[s_q.tail[q]] = enq_slot[q];
                s_d.tail[q] = enq_slot[q];
                s_d.cnt[q]  = s_q.cnt[q] + 1'b1;
            end else if (deq_v[q] && s_q.cnt[q] != '0) begin
                s_d.head[q] = s_q.link[s_q.head[q]];
                s_d.cnt[q]  = s_q.cnt[q] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bal_head_o     = s_q.head[bal_idx];
    assign fwd_head_o     = s_q.head[fwd_idx];
    assign bal_cnt_o      = s_q.cnt[bal_idx];
    assign fwd_cnt_o      = s_q.cnt[fwd_idx];
    assign rel_bal_v_o    = bal_rd_i && (s_q.cnt[bal_idx] != '0);
    assign rel_bal_slot_o = s_q.head[bal_idx];
    assign rel_fwd_v_o    = fwd_rd_i && (s_q.cnt[fwd_idx] != '0);
    assign rel_fwd_slot_o = s_q.head[fwd_idx];

    always_comb begin
        occ_sum = 0;
        for (int q = 0; q < Q; q++) occ_sum += 32'(s_q.cnt[q]);
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ_sum <= DEPTH); // R9
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_rd_i && fwd_cnt_o == '0 && !enq_fwd_v_i) |=> (s_q.cnt[$past(fwd_idx)] == '0)); // R6
    AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_bal_v_i && bal_rd_i && enq_bal_q_i == peer_i && bal_cnt_o != '0)
        |=> (s_q.cnt[$past(bal_idx)] == $past(bal_cnt_o))); // R7

endmodule

// File: rtl/defl_queue_mgr.sv
module defl_queue_mgr #(
    parameter int unsigned N      = 4,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DW     = 32,
    parameter int unsigned DROP_W = 16,
    localparam int unsigned PW = $clog2(N),
    localparam int unsigned SW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic [PW-1:0]     loc_dest,
    input  logic [DW-1:0]     loc_data,
    input  logic              dfl_valid,
    input  logic [PW-1:0]     dfl_dest,
    input  logic [DW-1:0]     dfl_data,
    input  logic [PW-1:0]     peer,
    input  logic              bal_rd,
    input  logic              fwd_rd,
    output logic              bal_valid,
    output logic [DW-1:0]     bal_data,
    output logic [PW-1:0]     bal_dest,
    output logic [CW-1:0]     bal_level,
    output logic              fwd_valid,
    output logic [DW-1:0]     fwd_data,
    output logic [PW-1:0]     fwd_dest,
    output logic [CW-1:0]     fwd_level,
    output logic [DROP_W-1:0] drop_count
);

    typedef struct packed {
        logic [DROP_W-1:0] drops;
    } top_st_t;

    top_st_t s_d, s_q;

    logic          gnt_dfl, gnt_loc;
    logic [SW-1:0] slot_dfl, slot_loc;
    logic [PW-1:0] rr_sel;
    logic [SW-1:0] bal_head, fwd_head;
    logic          rel_bal_v, rel_fwd_v;
    logic [SW-1:0] rel_bal_slot, rel_fwd_slot;

    logic [DW-1:0] mem_data [DEPTH];
    logic [PW-1:0] mem_dest [DEPTH];

    dqm_rr_spreader #(.N(N)) i_rr (
        .clk    (clk),
        .rst_n  (rst_n),
        .dest_i (loc_dest),
        .acc_i  (gnt_loc),
        .sel_o  (rr_sel)
    );

    dqm_slot_pool #(.DEPTH(DEPTH)) i_pool (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_dfl_i    (dfl_valid),
        .req_loc_i    (loc_valid),
        .rel_a_v_i    (rel_bal_v),
        .rel_a_slot_i (rel_bal_slot),
        .rel_b_v_i    (rel_fwd_v),
        .rel_b_slot_i (rel_fwd_slot),
        .gnt_dfl_o    (gnt_dfl),
        .slot_dfl_o   (slot_dfl),
        .gnt_loc_o    (gnt_loc),
        .slot_loc_o   (slot_loc)
    );

    dqm_queue_ctrl #(.N(N), .DEPTH(DEPTH)) i_qc (
        .clk            (clk),
        .rst_n          (rst_n),
        .enq_bal_v_i    (gnt_loc),
        .enq_bal_q_i    (rr_sel),
        .enq_bal_slot_i (slot_loc),
        .enq_fwd_v_i    (gnt_dfl),
        .enq_fwd_q_i    (dfl_dest),
        .enq_fwd_slot_i (slot_dfl),
        .peer_i         (peer),
        .bal_rd_i       (bal_rd),
        .fwd_rd_i       (fwd_rd),
        .bal_head_o     (bal_head),
        .fwd_head_o     (fwd_head),
        .bal_cnt_o      (bal_level),
        .fwd_cnt_o      (fwd_level),
        .rel_bal_v_o    (rel_bal_v),
        .rel_bal_slot_o (rel_bal_slot),
        .rel_fwd_v_o    (rel_fwd_v),
        .rel_fwd_slot_o (rel_fwd_slot)
    );

    // Shared cell storage: two write ports, distinct slots by construction
    always_ff @(posedge clk) begin
        if (gnt_loc) begin
            mem_data[slot_loc] <= loc_data;
            mem_dest[slot_loc] <= loc_dest;
        end
        if (gnt_dfl) begin
            mem_data[slot_dfl] <= dfl_data;
            mem_dest[slot_dfl] <= dfl_dest;
        end
    end

    always_comb begin
        s_d = s_q;
        s_d.drops = s_q.drops
                  + DROP_W'(loc_valid && !gnt_loc)
                  + DROP_W'(dfl_valid && !gnt_dfl);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bal_valid  = (bal_level != '0);
    assign bal_data   = mem_data[bal_head];
    assign bal_dest   = mem_dest[bal_head];
    assign fwd_valid  = (fwd_level != '0);
    assign fwd_data   = mem_data[fwd_head];
    assign fwd_dest   = mem_dest[fwd_head];
    assign drop_count = s_q.drops;

    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_valid && !dfl_valid) |=> $stable(drop_count)); // R9
    AST_FWD_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_dest == peer)); // R3

endmodule

// File: tb/test_defl_queue_mgr.sv
`timescale 1ns/1ps
module test_defl_queue_mgr;

    localparam int N = 4;
    localparam int D = 8;
    localparam int DW = 16;
    localparam int PW = 2;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loc_valid = 1'b0, dfl_valid = 1'b0, bal_rd = 1'b0, fwd_rd = 1'b0;
    logic [PW-1:0] loc_dest = '0, dfl_dest = '0, peer = '0;
    logic [DW-1:0] loc_data = '0, dfl_data = '0;
    logic bal_valid, fwd_valid;
    logic [DW-1:0] bal_data, fwd_data;
    logic [PW-1:0] bal_dest, fwd_dest;
    logic [CW-1:0] bal_level, fwd_level;
    logic [15:0] drop_count;

    always #2.5 clk = ~clk;

    defl_queue_mgr #(.N(N), .DEPTH(D), .DW(DW), .DROP_W(16)) i_defl_queue_mgr (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(loc_valid), .loc_dest(loc_dest), .loc_data(loc_data),
        .dfl_valid(dfl_valid), .dfl_dest(dfl_dest), .dfl_data(dfl_data),
        .peer(peer), .bal_rd(bal_rd), .fwd_rd(fwd_rd),
        .bal_valid(bal_valid), .bal_data(bal_data), .bal_dest(bal_dest), .bal_level(bal_level),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_dest(fwd_dest), .fwd_level(fwd_level),
        .drop_count(drop_count)
    );

    // Scoreboard: queues 0..N-1 balancing, N..2N-1 forwarding; entry {dest, data}
    logic [PW+DW-1:0] mq [2*N][$];
    int rr [N];
    int exp_drop = 0;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int occupancy();
        int s = 0;
        for (int q = 0; q < 2*N; q++) s += mq[q].size();
        return s;
    endfunction

    // One cycle: drive, compare outputs with the model, update the model
    task automatic step(input string rq, input bit lv, input int ld, input int ldat,
                        input bit dv, input int dd, input int ddat,
                        input int pr, input bit br, input bit fr);
        int freec;
        @(negedge clk);
        loc_valid = lv; loc_dest = PW'(ld); loc_data = DW'(ldat);
        dfl_valid = dv; dfl_dest = PW'(dd); dfl_data = DW'(ddat);
        peer = PW'(pr); bal_rd = br; fwd_rd = fr;
        #1;
        chk({rq, " R5 bal_valid"}, int'(bal_valid), int'(mq[pr].size() != 0));
        chk({rq, " R8 bal_level"}, int'(bal_level), mq[pr].size());
        if (mq[pr].size() != 0) begin
            chk({rq, " R4 bal_data"}, int'(bal_data), int'(mq[pr][0][DW-1:0]));
            chk({rq, " R4 bal_dest"}, int'(bal_dest), int'(mq[pr][0][PW+DW-1:DW]));
        end
        chk({rq, " R5 fwd_valid"}, int'(fwd_valid), int'(mq[N+pr].size() != 0));
        chk({rq, " R8 fwd_level"}, int'(fwd_level), mq[N+pr].size());
        if (mq[N+pr].size() != 0) begin
            chk({rq, " R4 fwd_data"}, int'(fwd_data), int'(mq[N+pr][0][DW-1:0]));
            chk({rq, " R3 fwd_dest"}, int'(fwd_dest), pr);
        end
        chk({rq, " R9 drop_count"}, int'(drop_count), exp_drop);
        // model: slots freed this cycle are not reusable until next (R11)
        freec = D - occupancy();
        if (br && mq[pr].size() != 0) void'(mq[pr].pop_front());
        if (fr && mq[N+pr].size() != 0) void'(mq[N+pr].pop_front());
        if (dv) begin
            if (freec >= 1) mq[N+dd].push_back({PW'(dd), DW'(ddat)});
            else exp_drop++;
        end
        if (lv) begin
            if (freec >= (dv ? 2 : 1)) begin
                mq[rr[ld]].push_back({PW'(ld), DW'(ldat)});
                rr[ld] = (rr[ld] + 1) % N;
            end else exp_drop++;
        end
    endtask

    task automatic drain(input string rq);
        for (int p = 0; p < N; p++) begin
            while (mq[p].size() != 0 || mq[N+p].size() != 0)
                step(rq, 0, 0, 0, 0, 0, 0, p, 1, 1);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) rr[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen at every peer
        for (int p = 0; p < N; p++) step("R1", 0, 0, 0, 0, 0, 0, p, 0, 0);

        // R2: one destination spread over all balancing queues
        for (int k = 0; k < 4; k++) step("R2", 1, 2, 'h100 + k, 0, 0, 0, 0, 0, 0);
        // R2: independent pointers for other destinations, interleaved
        step("R2", 1, 1, 'h200, 0, 0, 0, 1, 0, 0);
        step("R2", 1, 0, 'h300, 0, 0, 0, 2, 0, 0);
        step("R2", 1, 1, 'h201, 0, 0, 0, 3, 0, 0);
        step("R2", 1, 2, 'h104, 0, 0, 0, 0, 0, 0);
        drain("R2");

        // R3: deflected cells sorted by carried destination
        for (int k = 0; k < 3; k++) step("R3", 0, 0, 0, 1, 3, 'h400 + k, 0, 0, 0);
        step("R3", 0, 0, 0, 1, 0, 'h410, 3, 0, 0);
        drain("R3");

        // R6: read of empty queues ignored
        step("R6", 0, 0, 0, 0, 0, 0, 2, 1, 1);
        step("R6", 0, 0, 0, 0, 0, 0, 2, 0, 0);

        // R7: read+write same queue at counts 0, 1 and 2
        step("R7", 0, 0, 0, 1, 1, 'h500, 1, 0, 1);
        step("R7", 0, 0, 0, 1, 1, 'h501, 1, 0, 1);
        step("R7", 0, 0, 0, 1, 1, 'h502, 1, 0, 0);
        step("R7", 0, 0, 0, 1, 1, 'h503, 1, 0, 1);
        step("R7", 1, 3, 'h600, 0, 0, 0, 0, 0, 0);
        step("R7", 1, 3, 'h601, 0, 0, 0, 0, 1, 0);
        drain("R7");

        // R9: fill the shared memory, then overflow (pointer must not move)
        for (int k = 0; k < D; k++) step("R9", 1, 0, 'h700 + k, 0, 0, 0, 0, 0, 0);
        step("R9", 1, 0, 'h7f0, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 1, 2, 'h7f1, 0, 0, 0);
        drain("R9");
        step("R9", 1, 0, 'h7f2, 0, 0, 0, 0, 0, 0);
        drain("R9");

        // R10: one free slot, both arrive
        for (int k = 0; k < D - 1; k++) step("R10", 0, 0, 0, 1, k % N, 'h800 + k, 0, 0, 0);
        step("R10", 1, 1, 'h8f0, 1, 2, 'h8f1, 0, 0, 0);
        drain("R10");

        // R11: full memory, slot released and arrival in the same cycle
        for (int k = 0; k < D; k++) step("R11", 1, 3, 'h900 + k, 0, 0, 0, 0, 0, 0);
        step("R11", 1, 3, 'h9f0, 0, 0, 0, 1, 1, 0);
        step("R11", 1, 3, 'h9f1, 0, 0, 0, 1, 0, 0);
        drain("R11");
        step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule